// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Store Queue

This block sits between a processor load/store port and a word-wide lower-level memory port. It keeps 1 KB of data as 32 lines of 32 bytes, each found by a single index lookup on a 32-bit byte address. Loads that hit return data in the same cycle. Loads that miss fetch the whole line, one word at a time, and then complete as hits.

Every store goes to the lower level through a four-entry queue that drains in the background, so short bursts of stores do not stall the processor. A store that hits also merges its enabled bytes into the cached word. A store that misses leaves the cache unchanged. A load miss goes to memory ahead of queued stores unless one of those stores targets the same line. In that case the queue drains first, so the refill cannot return stale data.

The lower-level port carries one word per transaction. A request is held with all its fields unchanged until memory answers with a single-cycle acknowledge.

Top module: `wt_dm_cache`

## Requirements
- R1: After reset every line is invalid, no memory request is raised, and the first load to any address is a miss.
- R2: Address bits [4:0] pick the byte, bits [9:5] pick the line and bits [31:10] form the tag. A load hits only when the line is valid and its stored tag equals all 22 tag bits, so two addresses that differ only in tag evict each other.
- R3: A load hit raises cpu_ready in the cycle of the request, with the addressed word on cpu_rdata, and starts no memory traffic.
- R4: A load miss issues eight word reads at line base +0, +4, … +28 in ascending order with mem_be all ones. The line becomes valid only after the eighth word returns, and the load then completes with the correct word.
- R5: Every accepted store produces exactly one memory write with the same word address (byte address with bits [1:0] zero), data and byte enables. Writes reach memory in the order the stores were accepted.
- R6: A store hit updates only the bytes whose cpu_be bit is set (bit n covers data bits 8n+7..8n). A store miss does not allocate, so a later load to that line still misses.
- R7: The store queue holds four stores. A store is accepted in its first cycle while fewer than four are queued. With four queued, cpu_ready stays low until one has been written to memory.
- R8: A load miss whose line matches a queued store does not start its refill until that store has been written. The load returns the stored bytes.
- R9: A load miss to a line with no queued store is sent to memory before older queued stores. At most the one write already in flight precedes it.
- R10: mem_req, once raised, stays high with address, write flag and write data unchanged until the cycle mem_ack is high. Each request is served exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready on a load |
| mem_req | output | 1 | Lower-level transaction request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables (all ones on reads) |
| mem_ack | input | 1 | Single-cycle completion from memory |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The assertions check the following on every cycle:
- Memory requests hold steady until acknowledged, and every acknowledge meets a live request.
- The store queue is never pushed when full or popped when empty.
- A refill never runs while a queued store targets the line being filled.
- A line is never marked valid while it is already valid.

Only the bench scenarios can show the rest:
- the exact refill address sequence and the hit/miss outcome of each tag and index;
- merged store bytes seen in load data;
- the write order at memory;
- the stall of a fifth store;
- the order in which a load refill and queued stores reach memory, both with and without a line match.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
  // lower-level port owner
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_FILL  = 2'd1,
    MS_DRAIN = 2'd2
  } mport_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
`timescale 1ns/1ps
module wtc_tag_store #(
  parameter int LINES = 32,
  parameter int IDX_W = 5,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (inv_en)  valid_d[inv_idx]  = 1'b0;
    if (fill_en) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  // R4: the line being filled was invalidated when the refill began
  assert_fill_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !valid_q[fill_idx]);
endmodule

// File: rtl/wtc_data_store.sv
`timescale 1ns/1ps
module wtc_data_store #(
  parameter int LINES  = 32,
  parameter int WPL    = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_wsel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              st_en,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [WSEL_W-1:0] st_wsel,
  input  logic [DATA_W/8-1:0] st_be,
  input  logic [DATA_W-1:0] st_data,
  input  logic              fl_en,
  input  logic [IDX_W-1:0]  fl_idx,
  input  logic [WSEL_W-1:0] fl_wsel,
  input  logic [DATA_W-1:0] fl_data
);
  localparam int BE_W  = DATA_W / 8;
  localparam int WORDS = LINES * WPL;

  logic [DATA_W-1:0] arr [WORDS];

  always_ff @(posedge clk) begin
    if (fl_en) begin
      arr[{fl_idx, fl_wsel}] <= fl_data;
    end else if (st_en) begin
      for (int b = 0; b < BE_W; b++) begin
        if (st_be[b]) arr[{st_idx, st_wsel}][8*b +: 8] <= st_data[8*b +: 8];
      end
    end
  end

  assign rd_data = arr[{rd_idx, rd_wsel}];
endmodule

// File: rtl/wtc_wbuf.sv
`timescale 1ns/1ps
module wtc_wbuf #(
  parameter int DEPTH   = 4,
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32,
  parameter int LINEA_W = 27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [WADDR_W-1:0] push_waddr,
  input  logic [DATA_W-1:0]  push_data,
  input  logic [DATA_W/8-1:0] push_be,
  input  logic               pop,
  output logic [WADDR_W-1:0] head_waddr,
  output logic [DATA_W-1:0]  head_data,
  output logic [DATA_W/8-1:0] head_be,
  output logic               full,
  output logic               empty,
  input  logic [LINEA_W-1:0] q_line,
  output logic               q_conflict
);
  // DEPTH must be a power of two: pointers wrap naturally
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BE_W  = DATA_W / 8;

  logic [DEPTH-1:0]   vld_q, vld_d;
  logic [PTR_W-1:0]   hd_q, hd_d, tl_q, tl_d;
  logic [WADDR_W-1:0] e_addr [DEPTH];
  logic [DATA_W-1:0]  e_data [DEPTH];
  logic [BE_W-1:0]    e_be   [DEPTH];
  logic [DEPTH-1:0]   cf;

  always_comb begin
    vld_d = vld_q;
    hd_d  = hd_q;
    tl_d  = tl_q;
    if (pop) begin
      vld_d[hd_q] = 1'b0;
      hd_d        = hd_q + PTR_W'(1);
    end
    if (push) begin
      vld_d[tl_q] = 1'b1;
      tl_d        = tl_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      hd_q  <= '0;
      tl_q  <= '0;
    end else begin
      vld_q <= vld_d;
      hd_q  <= hd_d;
      tl_q  <= tl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[tl_q] <= push_waddr;
      e_data[tl_q] <= push_data;
      e_be[tl_q]   <= push_be;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
      assign cf[i] = vld_q[i] && (e_addr[i][WADDR_W-1 -: LINEA_W] == q_line);
    end
  endgenerate

  assign q_conflict = |cf;
  assign full       = &vld_q;
  assign empty      = ~|vld_q;
  assign head_waddr = e_addr[hd_q];
  assign head_data  = e_data[hd_q];
  assign head_be    = e_be[hd_q];

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/wt_dm_cache.sv
`timescale 1ns/1ps
module wt_dm_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 32,
  parameter int WB_DEPTH    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  output logic                cpu_ready,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic                mem_ack,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int BE_W    = DATA_W / 8;
  localparam int BSEL_W  = $clog2(BE_W);
  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int LINES   = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int WPL     = LINE_BYTES / BE_W;
  localparam int WSEL_W  = $clog2(WPL);
  localparam int WADDR_W = ADDR_W - BSEL_W;
  localparam int LINEA_W = ADDR_W - OFF_W;

  // address fields of the processor request
  logic [IDX_W-1:0]   cpu_idx;
  logic [TAG_W-1:0]   cpu_tag;
  logic [WSEL_W-1:0]  cpu_wsel;
  logic [LINEA_W-1:0] cpu_line;
  logic               unused_bytesel;

  assign cpu_idx        = cpu_addr[OFF_W +: IDX_W];
  assign cpu_tag        = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_wsel       = cpu_addr[BSEL_W +: WSEL_W];
  assign cpu_line       = cpu_addr[ADDR_W-1:OFF_W];
  assign unused_bytesel = ^cpu_addr[BSEL_W-1:0];

  mport_state_e       st_q, st_d;
  logic [WSEL_W-1:0]  cnt_q, cnt_d;
  logic [LINEA_W-1:0] line_q;

  logic lk_hit, rd_miss, store_go;
  logic fill_start, fill_last, fill_we, wb_pop;
  logic wb_full, wb_empty, wb_conflict;
  logic [LINEA_W-1:0] q_line;
  logic [WADDR_W-1:0] head_waddr;
  logic [DATA_W-1:0]  head_data;
  logic [BE_W-1:0]    head_be;

  assign rd_miss  = cpu_req && !cpu_we && !lk_hit;
  assign store_go = cpu_req && cpu_we && !wb_full && (st_q != MS_FILL);
  assign cpu_ready = cpu_req && (cpu_we ? (!wb_full && (st_q != MS_FILL)) : lk_hit);
  assign q_line   = (st_q == MS_FILL) ? line_q : cpu_line;

  // next-state logic of the lower-level port
  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    fill_start = 1'b0;
    fill_last  = 1'b0;
    fill_we    = 1'b0;
    wb_pop     = 1'b0;
    case (st_q)
      MS_IDLE: begin
        if (rd_miss && !wb_conflict) begin
          st_d       = MS_FILL;
          cnt_d      = '0;
          fill_start = 1'b1;
        end else if (!wb_empty) begin
          st_d = MS_DRAIN;
        end
      end
      MS_FILL: begin
        if (mem_ack) begin
          fill_we = 1'b1;
          cnt_d   = cnt_q + WSEL_W'(1);
          if (cnt_q == WSEL_W'(WPL - 1)) begin
            fill_last = 1'b1;
            st_d      = MS_IDLE;
          end
        end
      end
      MS_DRAIN: begin
        if (mem_ack) begin
          wb_pop = 1'b1;
          st_d   = MS_IDLE;
        end
      end
      default: st_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_start) line_q <= cpu_line;
  end

  assign mem_req   = (st_q != MS_IDLE);
  assign mem_we    = (st_q == MS_DRAIN);
  assign mem_addr  = (st_q == MS_FILL) ? {line_q, cnt_q, {BSEL_W{1'b0}}}
                                       : {head_waddr, {BSEL_W{1'b0}}};
  assign mem_wdata = head_data;
  assign mem_be    = (st_q == MS_FILL) ? {BE_W{1'b1}} : head_be;

  wtc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (cpu_idx),
    .lk_tag   (cpu_tag),
    .lk_hit   (lk_hit),
    .inv_en   (fill_start),
    .inv_idx  (cpu_idx),
    .fill_en  (fill_last),
    .fill_idx (line_q[IDX_W-1:0]),
    .fill_tag (line_q[LINEA_W-1:IDX_W])
  );

  wtc_data_store #(.LINES(LINES), .WPL(WPL), .DATA_W(DATA_W), .IDX_W(IDX_W),
                   .WSEL_W(WSEL_W)) u_data (
    .clk     (clk),
    .rd_idx  (cpu_idx),
    .rd_wsel (cpu_wsel),
    .rd_data (cpu_rdata),
    .st_en   (store_go && lk_hit),
    .st_idx  (cpu_idx),
    .st_wsel (cpu_wsel),
    .st_be   (cpu_be),
    .st_data (cpu_wdata),
    .fl_en   (fill_we),
    .fl_idx  (line_q[IDX_W-1:0]),
    .fl_wsel (cnt_q),
    .fl_data (mem_rdata)
  );

  wtc_wbuf #(.DEPTH(WB_DEPTH), .WADDR_W(WADDR_W), .DATA_W(DATA_W),
             .LINEA_W(LINEA_W)) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (store_go),
    .push_waddr (cpu_addr[ADDR_W-1:BSEL_W]),
    .push_data  (cpu_wdata),
    .push_be    (cpu_be),
    .pop        (wb_pop),
    .head_waddr (head_waddr),
    .head_data  (head_data),
    .head_be    (head_be),
    .full       (wb_full),
    .empty      (wb_empty),
    .q_line     (q_line),
    .q_conflict (wb_conflict)
  );

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  assert_ack_with_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> mem_req);
  assert_fill_no_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MS_FILL) |-> !wb_conflict);
endmodule

// File: tb/wt_dm_cache_tb.sv
`timescale 1ns/1ps
module wt_dm_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  always #2.5 clk = ~clk;

  wt_dm_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0;
  int lat = 1;
  int wcnt;
  logic [31:0] mm  [1024];
  logic [31:0] emm [1024];
  bit          lw [1024];
  logic [31:0] la [1024];
  logic [31:0] ld [1024];
  logic [3:0]  lb [1024];
  int          log_n;

  function automatic logic [31:0] pat(int w);
    return 32'h3C00_0000 + 32'(w) * 32'h0001_0007;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  // lower-level memory model with a transaction log
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
      log_n      = 0;
      for (int i = 0; i < 1024; i++) mm[i] = pat(i);
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt >= lat) begin
          mem_ack <= 1'b1;
          wcnt    <= 0;
          if (log_n < 1024) begin
            lw[log_n] = mem_we; la[log_n] = mem_addr;
            ld[log_n] = mem_wdata; lb[log_n] = mem_be;
            log_n = log_n + 1;
          end
          if (mem_we) mm[mem_addr[11:2]] = merge(mm[mem_addr[11:2]], mem_wdata, mem_be);
          else        mem_rdata <= mm[mem_addr[11:2]];
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cpu_access(input bit we, input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] be, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    cyc = 0;
    forever begin
      #1;
      cyc++;
      if (cpu_ready) break;
      @(negedge clk);
    end
    rd = cpu_rdata;
    if (we) emm[a[11:2]] = merge(emm[a[11:2]], d, be);
    @(posedge clk);
    #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, a, exp;
    int cyc, n0, n1, wi, ri, nw;
    int cy5 [5];
    bit ok;
    for (int i = 0; i < 1024; i++) emm[i] = pat(i);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 0);
    chk(log_n == 0, "R1", "memory traffic after reset", 32'(log_n), 0);

    // R1 / R4: first load misses and refills in ascending order
    n0 = log_n;
    cpu_access(0, 32'h0000_0008, 0, 0, rd, cyc);
    chk(rd == emm[2], "R4", "refill load data", rd, emm[2]);
    chk(log_n - n0 == 8 && cyc > 8, "R1", "first load must miss", 32'(log_n - n0), 8);
    ok = 1'b1;
    for (int k = 0; k < 8; k++)
      if (lw[n0+k] || la[n0+k] != 32'(4*k) || lb[n0+k] != 4'hF) ok = 1'b0;
    chk(ok, "R4", "refill word order", la[n0+7], 32'h1C);

    // R3: every word of the line hits in one cycle with no traffic
    for (int w = 0; w < 8; w++) begin
      n0 = log_n;
      cpu_access(0, 32'(4*w), 0, 0, rd, cyc);
      chk(rd == emm[w] && cyc == 1 && log_n == n0, "R3", "hit word", rd, emm[w]);
    end

    // R2: sweep all 32 indices with tag 1 (miss then hit)
    for (int i = 0; i < 32; i++) begin
      a = 32'h400 + 32'(i*32) + 32'((i%8)*4);
      n0 = log_n;
      cpu_access(0, a, 0, 0, rd, cyc);
      chk(rd == emm[a[11:2]] && log_n - n0 == 8 && la[n0] == {a[31:5], 5'd0},
          "R2", "index sweep miss", rd, emm[a[11:2]]);
      n1 = log_n;
      cpu_access(0, a, 0, 0, rd, cyc);
      chk(rd == emm[a[11:2]] && cyc == 1 && log_n == n1, "R3", "index sweep hit", rd, emm[a[11:2]]);
    end
    // R2: tag-0 line at index 0 was evicted
    n0 = log_n;
    cpu_access(0, 32'h0, 0, 0, rd, cyc);
    chk(log_n - n0 == 8 && rd == emm[0], "R2", "eviction by other tag", 32'(log_n - n0), 8);
    // R2: top tag bit alone distinguishes lines
    cpu_access(0, 32'h420, 0, 0, rd, cyc);
    n0 = log_n;
    cpu_access(0, 32'h8000_0420, 0, 0, rd, cyc);
    chk(log_n - n0 == 8 && rd == emm[32'h420 >> 2], "R2", "tag bit 31 compare", 32'(log_n - n0), 8);

    // R6 / R5: store hit merges bytes and writes through
    cpu_access(1, 32'h008, 32'hA1B2_C3D4, 4'b0101, rd, cyc);
    chk(cyc == 1, "R7", "store accepted at once", 32'(cyc), 1);
    n0 = log_n;
    cpu_access(0, 32'h008, 0, 0, rd, cyc);
    exp = merge(pat(2), 32'hA1B2_C3D4, 4'b0101);
    chk(rd == exp && cyc == 1, "R6", "store hit byte merge", rd, exp);
    repeat (20) @(posedge clk);
    #1;
    chk(log_n - n0 == 1 && lw[n0] && la[n0] == 32'h008 && lb[n0] == 4'b0101 &&
        ld[n0] == 32'hA1B2_C3D4, "R5", "write-through of store hit", la[n0], 32'h008);

    // R6 / R8: store miss does not allocate; load waits for the drain
    n0 = log_n;
    cpu_access(1, 32'h864, 32'h1122_3344, 4'b1110, rd, cyc);
    cpu_access(0, 32'h864, 0, 0, rd, cyc);
    exp = emm[32'h864 >> 2];
    chk(rd == exp, "R8", "load after queued store", rd, exp);
    chk(log_n - n0 == 9, "R6", "store miss then load miss", 32'(log_n - n0), 9);
    wi = -1; ri = -1;
    for (int k = n0; k < log_n; k++) begin
      if (lw[k] && la[k] == 32'h864 && wi < 0) wi = k;
      if (!lw[k] && la[k][31:5] == 27'(32'h860 >> 5) && ri < 0) ri = k;
    end
    chk(wi >= 0 && ri > wi, "R8", "write precedes refill of same line", 32'(ri), 32'(wi + 1));

    // R7 / R5 / R10: four stores absorbed, fifth stalls, order kept
    lat = 15;
    n0 = log_n;
    for (int s = 0; s < 5; s++)
      cpu_access(1, 32'h140 + 32'(4*s), 32'hD000_0000 + 32'(s), 4'hF, rd, cy5[s]);
    for (int s = 0; s < 4; s++)
      chk(cy5[s] == 1, "R7", "store within queue capacity", 32'(cy5[s]), 1);
    chk(cy5[4] > 1, "R7", "fifth store stalls", 32'(cy5[4]), 2);
    lat = 1;
    repeat (150) @(posedge clk);
    #1;
    chk(log_n - n0 == 5, "R10", "one write per held request", 32'(log_n - n0), 5);
    ok = 1'b1;
    for (int s = 0; s < 5; s++)
      if (!lw[n0+s] || la[n0+s] != 32'h140 + 32'(4*s) || ld[n0+s] != 32'hD000_0000 + 32'(s))
        ok = 1'b0;
    chk(ok, "R5", "write order at memory", la[n0+4], 32'h150);

    // R9: load miss overtakes older queued stores to other lines
    lat = 10;
    n0 = log_n;
    for (int s = 0; s < 3; s++)
      cpu_access(1, 32'h2A0 + 32'(4*s), 32'hE000_0000 + 32'(s), 4'hF, rd, cyc);
    cpu_access(0, 32'hC04, 0, 0, rd, cyc);
    chk(rd == emm[32'hC04 >> 2], "R9", "load data under queued stores", rd, emm[32'hC04 >> 2]);
    nw = 0; ri = -1;
    for (int k = n0; k < log_n; k++) begin
      if (!lw[k] && ri < 0) ri = k;
      if (lw[k] && ri < 0) nw++;
    end
    chk(ri >= 0 && nw <= 1, "R9", "writes ahead of refill", 32'(nw), 1);
    lat = 1;
    repeat (100) @(posedge clk);
    #1;
    nw = 0;
    for (int k = n0; k < log_n; k++) if (lw[k]) nw++;
    chk(nw == 3, "R5", "all queued stores written", 32'(nw), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule